// File: doc/BRIEF.md
# Stack and Interrupt Entry Sequencer

This block runs the stack side of an 8-bit processor core. The core hands it one command at a time. The sequencer then carries out the memory transfers the command needs over a single byte-wide request/ready port. It owns the 8-bit stack pointer and the interrupt-mask flag, and it computes the new 16-bit program counter for calls, returns, software breaks and hardware interrupt entry. The other condition flags (negative, overflow, decimal, zero, carry) enter as separate wires. They are captured when a command is accepted, packed into a status byte when one is pushed, and sent back out as separate wires after a status pull.

The stack occupies memory page 1, so byte addresses are 0x0100 + SP. A hardware interrupt is taken when the mask flag is clear and at least one line of the active-low request vector is low. The core asks for this check with a poll command. The sequencer also repeats the check by itself straight after a status pull, after a return-from-interrupt and after the mask is cleared. If an entry is taken there, it runs before the command completes.

Commands are accepted only while the sequencer is idle. Each command ends with a one-cycle `done`, and the results are valid in that same cycle.

Top module: `stack_irq_seq`

## Requirements
- R1: After reset, SP is 0xFD, the mask flag is 1, and `busy`, `done` and `mem_req` are all low.
- R2: Push byte (code 0) writes `cmd_data` at 0x0100+SP and then decrements SP. Pull byte (code 1) increments SP, reads 0x0100+SP and presents the byte on `pull_data`. SP wraps modulo 256 in both directions. No stack access leaves page 1.
- R3: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until `mem_rdy` is seen. Only one access is outstanding at a time.
- R4: `busy` is high from the cycle after a command is accepted through the `done` cycle. `done` lasts exactly one cycle. A `cmd_valid` that arrives while `busy` is high is ignored.
- R5: Push status (code 2) writes the byte {N, V, 1, B=1, D, I, Z, C}, with bit 7 first down to bit 0, and decrements SP.
- R6: Pull status (code 3) restores N, V, D, I, Z and C from bits 7, 6, 3, 2, 1 and 0 of the pulled byte, ignores bits 5 and 4, and raises `st_load` with `done`.
- R7: Call (code 4) pushes `cmd_pc` high byte first and then the low byte, and loads PC with `cmd_target`.
- R8: Return-from-subroutine (code 5) pulls the low byte and then the high byte, and loads PC with that value plus 1, with the carry propagating into the high byte.
- R9: Return-from-interrupt (code 6) pulls the status byte, then the PC low byte, then the PC high byte, and loads PC with exactly that value.
- R10: A hardware entry happens only when the mask is clear and `irq_req_n` is not all ones. The check is made on poll (code 10) and after codes 3, 6 and 8. When no entry is taken, codes 3, 8 and 10 leave `pc_load` low, and codes 8 and 10 make no memory access.
- R11: A hardware entry pushes the PC high byte, the PC low byte and then status with B=0. It sets the mask, reads PC low from 0xFFFE and then high from 0xFFFF, and reports `ent_cycles` = 7 with `done`.
- R12: Software break (code 7) pushes `cmd_pc`+1, then status with B=1. It sets the mask, loads PC from the same vector and reports `ent_cycles` = 0.
- R13: Code 9 sets the mask and code 8 clears it. Codes 11 to 15 complete with `done`, make no memory access, and change neither SP nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken while idle |
| cmd_op | input | 4 | Command code |
| cmd_data | input | 8 | Byte for push byte |
| cmd_pc | input | 16 | Current PC (call: final operand byte address; break: address after opcode) |
| cmd_target | input | 16 | Call destination |
| flg_n_in | input | 1 | Negative flag from core |
| flg_v_in | input | 1 | Overflow flag from core |
| flg_d_in | input | 1 | Decimal flag from core |
| flg_z_in | input | 1 | Zero flag from core |
| flg_c_in | input | 1 | Carry flag from core |
| irq_req_n | input | IRQ_W | Active-low interrupt request lines |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_rdy |
| mem_rdy | input | 1 | Access complete |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_load | output | 1 | With done: pc_out is a new PC |
| pc_out | output | 16 | Computed program counter |
| st_load | output | 1 | With done: pulled flags are valid |
| flg_n_out | output | 1 | Pulled negative flag |
| flg_v_out | output | 1 | Pulled overflow flag |
| flg_d_out | output | 1 | Pulled decimal flag |
| flg_z_out | output | 1 | Pulled zero flag |
| flg_c_out | output | 1 | Pulled carry flag |
| flag_i | output | 1 | Interrupt mask flag |
| pull_data | output | 8 | Byte from pull byte |
| sp | output | 8 | Stack pointer |
| ent_cycles | output | 8 | Cycle cost of a hardware entry, with done |

## Verification
The hardest case to reach is a return-from-interrupt or status pull that chains straight into a hardware entry. That path needs a stack frame whose status byte has the mask clear and a request line held low while the pull is in progress. The bench builds the frame with plain byte pushes of chosen values, lowers one request line, and then issues the return. It checks that the second frame was pushed using the flags and PC just pulled, that PC became the vector, and that 7 cycles were reported. It also stretches memory latency during one command and drives a second command in the middle of it, to show that the second command is dropped.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;

  typedef enum logic [3:0] {
    OP_PUSH = 4'd0,
    OP_PULL = 4'd1,
    OP_PHP  = 4'd2,
    OP_PLP  = 4'd3,
    OP_CALL = 4'd4,
    OP_RTS  = 4'd5,
    OP_RTI  = 4'd6,
    OP_BRK  = 4'd7,
    OP_CLI  = 4'd8,
    OP_SEI  = 4'd9,
    OP_POLL = 4'd10
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_WR_HI, S_WR_LO, S_WR_ST, S_WR_BYTE,
    S_RD_ST, S_RD_LO, S_RD_HI, S_RD_BYTE,
    S_VEC_LO, S_VEC_HI, S_CHK, S_FIN
  } st_e;

  function automatic logic [7:0] pack_status(input logic n, input logic v,
                                             input logic b, input logic d,
                                             input logic i, input logic z,
                                             input logic c);
    return {n, v, 1'b1, b, d, i, z, c};
  endfunction

endpackage

// File: rtl/stkseq_sp.sv
module stkseq_sp #(
  parameter logic [7:0] SP_INIT = 8'hFD,
  parameter logic [7:0] PAGE    = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_step,
  input  logic        pull_step,
  output logic [7:0]  sp,
  output logic [15:0] wr_addr,
  output logic [15:0] rd_addr
);

  logic [7:0] sp_q, sp_d, sp_inc;
  logic       step_en;

  assign sp_inc  = sp_q + 8'd1;
  assign step_en = push_step | pull_step;

  always_comb begin
    sp_d = sp_q;
    if (push_step)      sp_d = sp_q - 8'd1;
    else if (pull_step) sp_d = sp_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sp_q <= SP_INIT;
    else if (step_en) sp_q <= sp_d;
  end

  assign sp      = sp_q;
  assign wr_addr = {PAGE, sp_q};
  assign rd_addr = {PAGE, sp_inc};

  // R2
  sp_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_step |=> (sp_q == $past(sp_q) - 8'd1));
  // R2
  sp_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pull_step |=> (sp_q == $past(sp_q) + 8'd1));

endmodule

// File: rtl/stkseq_flags.sv
module stkseq_flags import stkseq_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_en,
  input  logic       n_in, v_in, d_in, z_in, c_in,
  input  logic       ld_en,
  input  logic       ld_n, ld_v, ld_d, ld_i, ld_z, ld_c,
  input  logic       i_set,
  input  logic       i_clr,
  input  logic       b_bit,
  output logic       n_q, v_q, d_q, z_q, c_q,
  output logic       i_q,
  output logic [7:0] packed_st
);

  logic       i_en, i_d;
  logic       fl_en;
  logic [4:0] fl_d;

  assign fl_en = cap_en | ld_en;
  assign fl_d  = ld_en ? {ld_n, ld_v, ld_d, ld_z, ld_c}
                       : {n_in, v_in, d_in, z_in, c_in};

  assign i_en = i_set | i_clr | ld_en;
  always_comb begin
    if (i_set)      i_d = 1'b1;
    else if (i_clr) i_d = 1'b0;
    else            i_d = ld_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {n_q, v_q, d_q, z_q, c_q} <= '0;
    end else if (fl_en) begin
      {n_q, v_q, d_q, z_q, c_q} <= fl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    i_q <= 1'b1;
    else if (i_en) i_q <= i_d;
  end

  assign packed_st = pack_status(n_q, v_q, b_bit, d_q, i_q, z_q, c_q);

  // R11
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    i_set |=> i_q);

endmodule

// File: rtl/stkseq_irqchk.sv
module stkseq_irqchk #(
  parameter int IRQ_W = 4
) (
  input  logic [IRQ_W-1:0] irq_req_n,
  input  logic             mask,
  output logic             pending
);

  assign pending = ~mask & ~(&irq_req_n);

endmodule

// File: rtl/stack_irq_seq.sv
module stack_irq_seq import stkseq_pkg::*; #(
  parameter int          IRQ_W        = 4,
  parameter logic [7:0]  SP_INIT      = 8'hFD,
  parameter logic [7:0]  STACK_PAGE   = 8'h01,
  parameter logic [15:0] VECTOR       = 16'hFFFE,
  parameter int          ENTRY_CYCLES = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_op,
  input  logic [7:0]       cmd_data,
  input  logic [15:0]      cmd_pc,
  input  logic [15:0]      cmd_target,
  input  logic             flg_n_in,
  input  logic             flg_v_in,
  input  logic             flg_d_in,
  input  logic             flg_z_in,
  input  logic             flg_c_in,
  input  logic [IRQ_W-1:0] irq_req_n,
  output logic             mem_req,
  output logic             mem_we,
  output logic [15:0]      mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata,
  input  logic             mem_rdy,
  output logic             busy,
  output logic             done,
  output logic             pc_load,
  output logic [15:0]      pc_out,
  output logic             st_load,
  output logic             flg_n_out,
  output logic             flg_v_out,
  output logic             flg_d_out,
  output logic             flg_z_out,
  output logic             flg_c_out,
  output logic             flag_i,
  output logic [7:0]       pull_data,
  output logic [7:0]       sp,
  output logic [7:0]       ent_cycles
);

  localparam logic [15:0] VECTOR_HI = VECTOR + 16'd1;
  localparam logic [7:0]  ENT_CYC   = 8'(ENTRY_CYCLES);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_i = rsync_q[1];

  st_e         st_q, st_d;
  op_e         op_q, op_d;
  logic [15:0] pc_q, pc_d, tgt_q, tgt_d;
  logic [7:0]  dat_q, dat_d;
  logic        hw_q, hw_d;

  logic        accept, fire, pending;
  logic        wr_state, rd_state;
  logic [15:0] wr_addr, rd_addr;
  logic [7:0]  packed_st;
  logic        i_set, i_clr, st_ld;
  op_e         cmd_e;

  assign cmd_e    = op_e'(cmd_op);
  assign accept   = (st_q == S_IDLE) && cmd_valid;
  assign fire     = mem_req && mem_rdy;
  assign wr_state = (st_q == S_WR_HI) || (st_q == S_WR_LO) ||
                    (st_q == S_WR_ST) || (st_q == S_WR_BYTE);
  assign rd_state = (st_q == S_RD_ST) || (st_q == S_RD_LO) ||
                    (st_q == S_RD_HI) || (st_q == S_RD_BYTE);

  stkseq_sp #(.SP_INIT(SP_INIT), .PAGE(STACK_PAGE)) u_sp (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .push_step (fire && wr_state),
    .pull_step (fire && rd_state),
    .sp        (sp),
    .wr_addr   (wr_addr),
    .rd_addr   (rd_addr)
  );

  assign st_ld = fire && (st_q == S_RD_ST);
  assign i_set = (fire && (st_q == S_WR_ST) && (hw_q || op_q == OP_BRK)) ||
                 (accept && cmd_e == OP_SEI);
  assign i_clr = accept && cmd_e == OP_CLI;

  stkseq_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .cap_en    (accept),
    .n_in      (flg_n_in),
    .v_in      (flg_v_in),
    .d_in      (flg_d_in),
    .z_in      (flg_z_in),
    .c_in      (flg_c_in),
    .ld_en     (st_ld),
    .ld_n      (mem_rdata[7]),
    .ld_v      (mem_rdata[6]),
    .ld_d      (mem_rdata[3]),
    .ld_i      (mem_rdata[2]),
    .ld_z      (mem_rdata[1]),
    .ld_c      (mem_rdata[0]),
    .i_set     (i_set),
    .i_clr     (i_clr),
    .b_bit     (~hw_q),
    .n_q       (flg_n_out),
    .v_q       (flg_v_out),
    .d_q       (flg_d_out),
    .z_q       (flg_z_out),
    .c_q       (flg_c_out),
    .i_q       (flag_i),
    .packed_st (packed_st)
  );

  stkseq_irqchk #(.IRQ_W(IRQ_W)) u_irq (
    .irq_req_n (irq_req_n),
    .mask      (flag_i),
    .pending   (pending)
  );

  // next-state logic
  always_comb begin
    st_d      = st_q;
    op_d      = op_q;
    pc_d      = pc_q;
    tgt_d     = tgt_q;
    dat_d     = dat_q;
    hw_d      = hw_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = wr_addr;
    mem_wdata = dat_q;
    case (st_q)
      S_IDLE: begin
        if (cmd_valid) begin
          op_d  = cmd_e;
          pc_d  = cmd_pc;
          tgt_d = cmd_target;
          dat_d = cmd_data;
          hw_d  = 1'b0;
          case (cmd_e)
            OP_PUSH: st_d = S_WR_BYTE;
            OP_PULL: st_d = S_RD_BYTE;
            OP_PHP:  st_d = S_WR_ST;
            OP_PLP:  st_d = S_RD_ST;
            OP_CALL: st_d = S_WR_HI;
            OP_RTS:  st_d = S_RD_LO;
            OP_RTI:  st_d = S_RD_ST;
            OP_BRK: begin
              pc_d = cmd_pc + 16'd1;
              st_d = S_WR_HI;
            end
            OP_CLI, OP_POLL: st_d = S_CHK;
            default: st_d = S_FIN;
          endcase
        end
      end
      S_WR_HI: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = pc_q[15:8];
        if (mem_rdy) st_d = S_WR_LO;
      end
      S_WR_LO: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = pc_q[7:0];
        if (mem_rdy) begin
          if (op_q == OP_CALL) begin
            pc_d = tgt_q;
            st_d = S_FIN;
          end else begin
            st_d = S_WR_ST;
          end
        end
      end
      S_WR_ST: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = packed_st;
        if (mem_rdy) st_d = (hw_q || op_q == OP_BRK) ? S_VEC_LO : S_FIN;
      end
      S_WR_BYTE: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_rdy) st_d = S_FIN;
      end
      S_RD_ST: begin
        mem_req  = 1'b1;
        mem_addr = rd_addr;
        if (mem_rdy) st_d = (op_q == OP_RTI) ? S_RD_LO : S_CHK;
      end
      S_RD_LO: begin
        mem_req  = 1'b1;
        mem_addr = rd_addr;
        if (mem_rdy) begin
          pc_d[7:0] = mem_rdata;
          st_d      = S_RD_HI;
        end
      end
      S_RD_HI: begin
        mem_req  = 1'b1;
        mem_addr = rd_addr;
        if (mem_rdy) begin
          if (op_q == OP_RTS) begin
            pc_d = {mem_rdata, pc_q[7:0]} + 16'd1;
            st_d = S_FIN;
          end else begin
            pc_d[15:8] = mem_rdata;
            st_d       = S_CHK;
          end
        end
      end
      S_RD_BYTE: begin
        mem_req  = 1'b1;
        mem_addr = rd_addr;
        if (mem_rdy) begin
          dat_d = mem_rdata;
          st_d  = S_FIN;
        end
      end
      S_VEC_LO: begin
        mem_req  = 1'b1;
        mem_addr = VECTOR;
        if (mem_rdy) begin
          pc_d[7:0] = mem_rdata;
          st_d      = S_VEC_HI;
        end
      end
      S_VEC_HI: begin
        mem_req  = 1'b1;
        mem_addr = VECTOR_HI;
        if (mem_rdy) begin
          pc_d[15:8] = mem_rdata;
          st_d       = S_FIN;
        end
      end
      S_CHK: begin
        if (pending) begin
          hw_d = 1'b1;
          st_d = S_WR_HI;
        end else begin
          st_d = S_FIN;
        end
      end
      S_FIN:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q  <= S_IDLE;
      op_q  <= OP_PUSH;
      pc_q  <= '0;
      tgt_q <= '0;
      dat_q <= '0;
      hw_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept || fire) begin
        op_q  <= op_d;
        pc_q  <= pc_d;
        tgt_q <= tgt_d;
        dat_q <= dat_d;
      end
      if (accept || st_q == S_CHK) hw_q <= hw_d;
    end
  end

  assign busy       = (st_q != S_IDLE);
  assign done       = (st_q == S_FIN);
  assign pc_load    = done && (hw_q || op_q == OP_CALL || op_q == OP_RTS ||
                               op_q == OP_RTI || op_q == OP_BRK);
  assign st_load    = done && (op_q == OP_PLP || op_q == OP_RTI);
  assign ent_cycles = (done && hw_q) ? ENT_CYC : 8'd0;
  assign pc_out     = pc_q;
  assign pull_data  = dat_q;

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata)));
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    done |=> (!done && !busy));
  // R11
  entry_mask_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (done && ent_cycles != 8'd0) |-> flag_i);
  // R5
  stat_bit5_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mem_req && mem_we && st_q == S_WR_ST) |-> mem_wdata[5]);

endmodule

// File: tb/stack_irq_seq_bench.sv
`timescale 1ns/1ps
module stack_irq_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [7:0]  cmd_data = '0;
  logic [15:0] cmd_pc = '0, cmd_target = '0;
  logic        fn = 0, fv = 0, fd = 0, fz = 0, fc = 0;
  logic [3:0]  irq_n = 4'hF;
  logic        mem_req, mem_we, mem_rdy;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        busy, done, pc_load, st_load, flag_i;
  logic        on, ov, od, oz, oc;
  logic [15:0] pc_out;
  logic [7:0]  pull_data, sp, ent_cycles;

  always #4 clk = ~clk;

  stack_irq_seq u_stack_irq_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_pc(cmd_pc), .cmd_target(cmd_target),
    .flg_n_in(fn), .flg_v_in(fv), .flg_d_in(fd), .flg_z_in(fz), .flg_c_in(fc),
    .irq_req_n(irq_n), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
    .busy(busy), .done(done), .pc_load(pc_load), .pc_out(pc_out),
    .st_load(st_load), .flg_n_out(on), .flg_v_out(ov), .flg_d_out(od),
    .flg_z_out(oz), .flg_c_out(oc), .flag_i(flag_i), .pull_data(pull_data),
    .sp(sp), .ent_cycles(ent_cycles)
  );

  // memory model: stack page plus vector bytes
  logic [7:0] stk [0:255];
  logic [7:0] vec_lo = 8'hDE, vec_hi = 8'hC0;
  int         lat = 0, wcnt = 0, acc_cnt = 0, bad_cnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rdy   <= 1'b0;
      mem_rdata <= 8'h00;
      wcnt      <= 0;
    end else if (mem_rdy) begin
      mem_rdy <= 1'b0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_rdy <= 1'b1;
        wcnt    <= 0;
        acc_cnt <= acc_cnt + 1;
        if (mem_we) begin
          if (mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
          else bad_cnt <= bad_cnt + 1;
        end else begin
          if (mem_addr[15:8] == 8'h01) mem_rdata <= stk[mem_addr[7:0]];
          else if (mem_addr == 16'hFFFE) mem_rdata <= vec_lo;
          else if (mem_addr == 16'hFFFF) mem_rdata <= vec_hi;
          else begin
            mem_rdata <= 8'h00;
            bad_cnt   <= bad_cnt + 1;
          end
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  int         n_chk = 0, n_bad = 0;
  logic [7:0] sp_m;
  int         acc0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // issue one command and wait for done (sampled on the falling edge)
  task automatic issue(input logic [3:0] op, input logic [15:0] pc,
                       input logic [15:0] tgt, input logic [7:0] data);
    acc0 = acc_cnt;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_pc = pc; cmd_target = tgt; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < 300 && !done; k++) @(negedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R4: actual no done expected done for op %0d", op);
    end
  endtask

  task automatic t_reset();
    check("R1 sp", sp, 8'hFD);
    check("R1 mask", flag_i, 1);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 req", mem_req, 0);
    sp_m = 8'hFD;
  endtask

  task automatic t_push_pull();
    issue(4'd0, 16'h0, 16'h0, 8'hA5);
    check("R2 push mem", stk[sp_m], 8'hA5);
    sp_m = sp_m - 8'd1;
    check("R2 push sp", sp, sp_m);
    issue(4'd1, 16'h0, 16'h0, 8'h00);
    sp_m = sp_m + 8'd1;
    check("R2 pull data", pull_data, 8'hA5);
    check("R2 pull sp", sp, sp_m);
  endtask

  task automatic t_wrap();
    stk[8'h00] = 8'h11;
    for (int k = 0; k < 3; k++) begin
      issue(4'd1, 16'h0, 16'h0, 8'h00);
      sp_m = sp_m + 8'd1;
    end
    check("R2 wrap up", sp, 8'h00);
    check("R2 wrap read", pull_data, 8'h11);
    issue(4'd0, 16'h0, 16'h0, 8'h3C);
    sp_m = sp_m - 8'd1;
    check("R2 wrap down", sp, 8'hFF);
    check("R2 wrap mem", stk[8'h00], 8'h3C);
    issue(4'd1, 16'h0, 16'h0, 8'h00);
    sp_m = sp_m + 8'd1;
    check("R2 wrap pull", pull_data, 8'h3C);
  endtask

  task automatic t_php();
    fn = 1; fv = 0; fd = 1; fz = 0; fc = 1;
    issue(4'd2, 16'h0, 16'h0, 8'h00);
    check("R5 status a", stk[sp_m], 8'hBD);
    sp_m = sp_m - 8'd1;
    check("R5 sp", sp, sp_m);
    fn = 0; fv = 1; fd = 0; fz = 1; fc = 0;
    issue(4'd2, 16'h0, 16'h0, 8'h00);
    check("R5 status b", stk[sp_m], 8'h76);
    sp_m = sp_m - 8'd1;
  endtask

  task automatic t_plp();
    irq_n = 4'hF;
    issue(4'd0, 16'h0, 16'h0, 8'hC9);
    sp_m = sp_m - 8'd1;
    acc0 = acc_cnt;
    issue(4'd3, 16'h0, 16'h0, 8'h00);
    sp_m = sp_m + 8'd1;
    check("R6 flags a", {on, ov, od, oz, oc, flag_i}, 6'b111010);
    check("R6 st_load", st_load, 1);
    check("R10 no pc", pc_load, 0);
    issue(4'd0, 16'h0, 16'h0, 8'h32);
    sp_m = sp_m - 8'd1;
    issue(4'd3, 16'h0, 16'h0, 8'h00);
    sp_m = sp_m + 8'd1;
    check("R6 flags b", {on, ov, od, oz, oc, flag_i}, 6'b000100);
    check("R6 sp", sp, sp_m);
    issue(4'd9, 16'h0, 16'h0, 8'h00);
    check("R13 set mask", flag_i, 1);
  endtask

  task automatic t_call_rts();
    issue(4'd4, 16'h1234, 16'h5678, 8'h00);
    check("R7 hi", stk[sp_m], 8'h12);
    check("R7 lo", stk[sp_m - 8'd1], 8'h34);
    sp_m = sp_m - 8'd2;
    check("R7 pc", {pc_load, pc_out}, {1'b1, 16'h5678});
    issue(4'd5, 16'h0, 16'h0, 8'h00);
    sp_m = sp_m + 8'd2;
    check("R8 pc", {pc_load, pc_out}, {1'b1, 16'h1235});
    check("R8 sp", sp, sp_m);
    issue(4'd4, 16'h40FF, 16'h0000, 8'h00);
    sp_m = sp_m - 8'd2;
    issue(4'd5, 16'h0, 16'h0, 8'h00);
    sp_m = sp_m + 8'd2;
    check("R8 carry", pc_out, 16'h4100);
  endtask

  task automatic t_masked();
    irq_n = 4'b1110;
    issue(4'd10, 16'h1111, 16'h0, 8'h00);
    check("R10 masked", {pc_load, ent_cycles}, 9'h0);
    check("R10 no access", acc_cnt - acc0, 0);
    irq_n = 4'hF;
    issue(4'd8, 16'h1111, 16'h0, 8'h00);
    check("R13 clear mask", flag_i, 0);
    check("R10 quiet", {pc_load, 8'(acc_cnt - acc0)}, 9'h0);
  endtask

  task automatic t_entry();
    fn = 0; fv = 0; fd = 0; fz = 0; fc = 0;
    lat = 2;
    irq_n = 4'b1011;
    issue(4'd10, 16'h3456, 16'h0, 8'h00);
    check("R11 hi", stk[sp_m], 8'h34);
    check("R11 lo", stk[sp_m - 8'd1], 8'h56);
    check("R11 status", stk[sp_m - 8'd2], 8'h20);
    sp_m = sp_m - 8'd3;
    check("R11 sp", sp, sp_m);
    check("R11 pc", {pc_load, pc_out}, {1'b1, 16'hC0DE});
    check("R11 cycles", ent_cycles, 8'd7);
    check("R11 mask", flag_i, 1);
    lat = 0;
  endtask

  task automatic t_rti();
    irq_n = 4'hF;
    issue(4'd6, 16'h0, 16'h0, 8'h00);
    sp_m = sp_m + 8'd3;
    check("R9 pc", {pc_load, pc_out}, {1'b1, 16'h3456});
    check("R9 mask", flag_i, 0);
    check("R9 st_load", st_load, 1);
    check("R9 no entry", ent_cycles, 8'd0);
  endtask

  task automatic t_rti_chain();
    issue(4'd0, 16'h0, 16'h0, 8'h77);
    issue(4'd0, 16'h0, 16'h0, 8'h88);
    issue(4'd0, 16'h0, 16'h0, 8'h01);
    irq_n = 4'b0111;
    issue(4'd6, 16'h0, 16'h0, 8'h00);
    check("R10 chain hi", stk[sp_m], 8'h77);
    check("R10 chain lo", stk[sp_m - 8'd1], 8'h88);
    check("R11 chain status", stk[sp_m - 8'd2], 8'h21);
    sp_m = sp_m - 8'd3;
    check("R10 chain pc", pc_out, 16'hC0DE);
    check("R10 chain cycles", ent_cycles, 8'd7);
    check("R6 chain carry", {oc, st_load}, 2'b11);
    issue(4'd0, 16'h0, 16'h0, 8'h80);
    sp_m = sp_m - 8'd1;
    issue(4'd3, 16'h6000, 16'h0, 8'h00);
    sp_m = sp_m + 8'd1;
    check("R10 plp hi", stk[sp_m], 8'h60);
    check("R10 plp status", stk[sp_m - 8'd2], 8'hA0);
    sp_m = sp_m - 8'd3;
    check("R10 plp entry", {pc_load, ent_cycles}, {1'b1, 8'd7});
  endtask

  task automatic t_brk();
    irq_n = 4'hF;
    issue(4'd8, 16'h0, 16'h0, 8'h00);
    fn = 0; fv = 0; fd = 0; fz = 0; fc = 1;
    issue(4'd7, 16'h2000, 16'h0, 8'h00);
    check("R12 hi", stk[sp_m], 8'h20);
    check("R12 lo", stk[sp_m - 8'd1], 8'h01);
    check("R12 status", stk[sp_m - 8'd2], 8'h31);
    sp_m = sp_m - 8'd3;
    check("R12 pc", {pc_load, pc_out}, {1'b1, 16'hC0DE});
    check("R12 cycles", ent_cycles, 8'd0);
    check("R12 mask", flag_i, 1);
  endtask

  task automatic t_busy_ignore();
    lat = 3;
    acc0 = acc_cnt;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 4'd0; cmd_data = 8'h5A;
    @(negedge clk);
    cmd_op = 4'd1;
    check("R4 busy", busy, 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < 300 && !done; k++) @(negedge clk);
    check("R4 done", done, 1);
    check("R4 one access", acc_cnt - acc0, 1);
    check("R4 mem", stk[sp_m], 8'h5A);
    sp_m = sp_m - 8'd1;
    check("R4 sp", sp, sp_m);
    @(negedge clk);
    check("R4 pulse", {done, busy}, 2'b00);
    lat = 0;
  endtask

  task automatic t_undef();
    issue(4'd13, 16'h0, 16'h0, 8'h00);
    check("R13 undef access", acc_cnt - acc0, 0);
    check("R13 undef sp", sp, sp_m);
    check("R13 undef mask", {flag_i, pc_load}, 2'b10);
    check("R2 page", bad_cnt, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_push_pull();
    t_wrap();
    t_php();
    t_plp();
    t_call_rts();
    t_masked();
    t_entry();
    t_rti();
    t_rti_chain();
    t_brk();
    t_busy_ignore();
    t_undef();
    repeat (2) @(negedge clk);
    summary();
  end

endmodule